// File: doc/BRIEF.md
# Angle INL Correction Interpolator

This block corrects a 16-bit binary shaft angle for a repeatable integral nonlinearity error. The correction profile is a set of 180 signed offsets, one every 2° around the full turn, held inside the block as fixed-point constants in units of 1/64 arc-minute. For each valid input angle the block finds the table segment that contains the angle. It interpolates linearly between the segment's two end entries and converts the arc-minute result to angle LSBs with rounding. It then adds that amount to the angle modulo one full turn.

The datapath is a three-stage pipeline. The first stage scales the angle by 180/65536 to obtain a segment index and an 8-bit fraction. The second stage reads the two bounding entries and interpolates. The third stage converts units, rounds and adds. A valid flag travels alongside the data. When no valid word is presented, the output word keeps its last value.

Top module: `ainl_corrector`

## Requirements
- R1: While reset is high and after it, until the first valid word emerges, `out_vld` is 0 and `out_ang` is 0.
- R2: `out_vld` equals `in_vld` delayed by exactly 3 clock cycles.
- R3: Table entry k (angle 2k degrees, k = 0..179) has value e(k) = (((37·k) mod 97) − 48)·8 in units of 1/64 arc-minute, so every entry lies within ±6 arc-minutes.
- R4: The segment index is k = floor(A·180 / 65536) and the fraction is f = floor((A·180 mod 65536) / 256), an 8-bit value, where A is the unsigned input angle (MSB = 180°, LSB = 360°/65536).
- R5: The interpolated correction is c = e(k)·256 + f·(e(k+1) − e(k)), in units of 2^-14 arc-minute.
- R6: For k = 179 the upper bounding entry is e(0), so the segment from 358° wraps to 0°.
- R7: The correction in LSBs is c·65536 / (21600·2^14), rounded to the nearest integer with halves rounded away from zero.
- R8: `out_ang` = (A + correction) mod 65536, wrapping in both directions across 0°.
- R9: A cycle without a valid input leaves `out_ang` unchanged three cycles later and drives `out_vld` low.
- R10: An angle whose fraction is 0 receives the converted entry e(k) alone, with no contribution from the neighbouring entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input angle is valid this cycle |
| in_ang | input | 16 | Uncorrected binary angle |
| out_vld | output | 1 | Corrected angle is valid |
| out_ang | output | 16 | Corrected binary angle |

## Verification
A wrong segment index or fraction shows up three cycles later as an output that differs from the arithmetic expectation by one or more LSBs, usually only in some regions of the turn. For that reason every one of the 65536 angles is pushed through in a scrambled order. Errors near 358° and at 0° expose a broken wrap of the segment or of the sum. Errors at half-LSB points expose a rounding fault. Idle cycles mixed into the stream show whether the valid flag slips relative to the data and whether an empty slot disturbs the held output word.

// File: rtl/ainl_pkg.sv
package ainl_pkg;

    // Datapath geometry
    localparam int ANG_W    = 16;                 // binary angle width
    localparam int N_ENT    = 180;                // table entries per turn
    localparam int IDX_W    = $clog2(N_ENT);      // segment index width
    localparam int FRAC_W   = 8;                  // interpolation fraction bits
    localparam int ENT_FRAC = 6;                  // fractional bits of a table entry (arc-minutes)
    localparam int ENT_W    = 11;                 // signed table entry width
    localparam int PROD_W   = ANG_W + IDX_W;      // angle * N_ENT product width
    localparam int CORR_W   = ENT_W + FRAC_W + 1; // interpolated correction width
    localparam int NUM_W    = CORR_W + ANG_W + 1; // conversion numerator width

    // Table profile generator
    localparam int TBL_MUL   = 37;
    localparam int TBL_MOD   = 97;
    localparam int TBL_OFS   = 48;
    localparam int TBL_SCALE = 8;
    localparam int TBL_MAX   = TBL_OFS * TBL_SCALE;

    // Unit conversion: arc-minutes per turn and divisor for the scaled product
    localparam longint MIN_PER_TURN = 21600;
    localparam longint CONV_DEN     = MIN_PER_TURN <<< (ENT_FRAC + FRAC_W);
    localparam longint CONV_HALF    = CONV_DEN / 2;
    localparam int     MAX_LSB      =
        int'((longint'(TBL_MAX) <<< ANG_W) / (MIN_PER_TURN <<< ENT_FRAC)) + 1;

    typedef struct packed {
        logic                    vld;
        logic [ANG_W-1:0]        ang;
        logic [IDX_W-1:0]        idx;
        logic [FRAC_W-1:0]       frac;
    } loc_t;

    typedef struct packed {
        logic                    vld;
        logic [ANG_W-1:0]        ang;
        logic signed [CORR_W-1:0] corr;
    } itp_t;

    function automatic logic signed [ENT_W-1:0] tbl_val(input int k);
        int v;
        v = (((k * TBL_MUL) % TBL_MOD) - TBL_OFS) * TBL_SCALE;
        return ENT_W'(v);
    endfunction

endpackage

// File: rtl/ainl_locate.sv
module ainl_locate
    import ainl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ANG_W-1:0] in_ang,
    output loc_t             q
);

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(in_ang) * PROD_W'(N_ENT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_vld;
            if (in_vld) begin
                q.ang  <= in_ang;
                q.idx  <= IDX_W'(prod >> ANG_W);
                q.frac <= FRAC_W'(prod >> (ANG_W - FRAC_W));
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        q.vld |-> (q.idx < IDX_W'(N_ENT))); // R4

endmodule

// File: rtl/ainl_interp.sv
module ainl_interp
    import ainl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  loc_t d,
    output itp_t q
);

    localparam int MAXC = TBL_MAX <<< FRAC_W;

    logic signed [ENT_W-1:0] rom [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign rom[g] = tbl_val(g);
    end

    logic [IDX_W-1:0]         nxt;
    logic signed [CORR_W-1:0] lo_x;
    logic signed [CORR_W-1:0] hi_x;
    logic signed [CORR_W-1:0] corr;

    always_comb begin
        nxt  = (d.idx == IDX_W'(N_ENT - 1)) ? '0 : d.idx + IDX_W'(1);
        lo_x = CORR_W'(rom[d.idx]);
        hi_x = CORR_W'(rom[nxt]);
        corr = (lo_x <<< FRAC_W)
             + CORR_W'($signed({1'b0, d.frac})) * (hi_x - lo_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= d.vld;
            if (d.vld) begin
                q.ang  <= d.ang;
                q.corr <= corr;
            end
        end
    end

    AST_CORR_BOUND: assert property (@(posedge clk) disable iff (rst)
        q.vld |-> (q.corr <= CORR_W'(MAXC) && q.corr >= -CORR_W'(MAXC))); // R5

endmodule

// File: rtl/ainl_apply.sv
module ainl_apply
    import ainl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  itp_t             d,
    output logic             out_vld,
    output logic [ANG_W-1:0] out_ang
);

    logic signed [NUM_W-1:0] num;
    logic                    neg;
    logic [NUM_W-1:0]        mag;
    logic [NUM_W-1:0]        quo;
    logic [NUM_W-1:0]        shift;
    logic [ANG_W-1:0]        sum;

    always_comb begin
        num   = $signed(NUM_W'(d.corr)) <<< ANG_W;
        neg   = num[NUM_W-1];
        mag   = neg ? NUM_W'(-num) : NUM_W'(num);
        quo   = (mag + NUM_W'(CONV_HALF)) / NUM_W'(CONV_DEN);
        shift = neg ? (~quo + NUM_W'(1)) : quo;
        sum   = d.ang + ANG_W'(shift);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_ang <= '0;
        end else begin
            out_vld <= d.vld;
            if (d.vld) begin
                out_ang <= sum;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !d.vld |=> $stable(out_ang)); // R9

endmodule

// File: rtl/ainl_corrector.sv
module ainl_corrector
    import ainl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ANG_W-1:0] in_ang,
    output logic             out_vld,
    output logic [ANG_W-1:0] out_ang
);

    loc_t s1;
    itp_t s2;

    ainl_locate u_locate (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_vld),
        .in_ang (in_ang),
        .q      (s1)
    );

    ainl_interp u_interp (
        .clk (clk),
        .rst (rst),
        .d   (s1),
        .q   (s2)
    );

    ainl_apply u_apply (
        .clk     (clk),
        .rst     (rst),
        .d       (s2),
        .out_vld (out_vld),
        .out_ang (out_ang)
    );

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        (since_rst != 2'd3) |-> !out_vld); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_vld) |->
            ($signed(ANG_W'(out_ang - $past(in_ang, 3))) <= MAX_LSB &&
             $signed(ANG_W'(out_ang - $past(in_ang, 3))) >= -MAX_LSB)); // R7

endmodule

// File: tb/ainl_corrector_tb.sv
module ainl_corrector_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] in_ang = '0;
    logic        out_vld;
    logic [15:0] out_ang;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected-output history, slot 0 = newest
    bit          hv [3];
    int          ha [3];
    string       ht [3];
    int          last_out = 0;

    always #2.5 clk = ~clk;

    ainl_corrector dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_ang  (in_ang),
        .out_vld (out_vld),
        .out_ang (out_ang)
    );

    // R3: table entry in 1/64 arc-minute
    function automatic longint ent(input int k);
        return longint'((((k * 37) % 97) - 48) * 8);
    endfunction

    function automatic int model(input int a, output string tag);
        longint p, c, num, den, q;
        int k, fr, k2, r;
        p   = longint'(a) * 180;
        k   = int'(p / 65536);                    // R4
        fr  = int'((p % 65536) / 256);
        k2  = (k == 179) ? 0 : k + 1;             // R6
        c   = ent(k) * 256 + longint'(fr) * (ent(k2) - ent(k)); // R5
        num = c * 65536;
        den = longint'(21600) * 16384;
        if (num >= 0) q = (num + den / 2) / den;  // R7
        else          q = -((-num + den / 2) / den);
        r   = int'((longint'(a) + q + 65536) % 65536); // R8
        if (k == 179)                        tag = "R6 upper segment wrap";
        else if (fr == 0)                    tag = "R10 on table point";
        else if (longint'(a) + q > 65535 || longint'(a) + q < 0)
                                             tag = "R8 sum wraps";
        else                                 tag = "R3 R4 R5 R7 interpolation";
        return r;
    endfunction

    task automatic check_slot();
        checks++;
        if (out_vld !== hv[2]) begin
            errors++;
            $display("FAIL R2 out_vld actual=%0b expected=%0b", out_vld, hv[2]);
        end
        checks++;
        if (hv[2]) begin
            if (int'(out_ang) != ha[2]) begin
                errors++;
                $display("FAIL %s out_ang actual=%0d expected=%0d", ht[2], out_ang, ha[2]);
            end
            last_out = ha[2];
        end else begin
            if (int'(out_ang) != last_out) begin
                errors++;
                $display("FAIL R9 held out_ang actual=%0d expected=%0d", out_ang, last_out);
            end
        end
    endtask

    task automatic step(input bit v, input int a);
        string tg;
        int    e;
        @(negedge clk);
        check_slot();
        hv[2] = hv[1]; ha[2] = ha[1]; ht[2] = ht[1];
        hv[1] = hv[0]; ha[1] = ha[0]; ht[1] = ht[0];
        e = v ? model(a, tg) : 0;
        hv[0] = v; ha[0] = e; ht[0] = tg;
        in_vld = v;
        in_ang = 16'(a);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; ha[i] = 0; ht[i] = "";
        end
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_ang !== 16'd0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_vld, out_ang);
        end
        rst = 1'b0;
        // R1: still quiet during pipeline fill
        step(1'b0, 0);
        step(1'b0, 0);
        // directed corners: 0 deg, just below 360, a table point, R6 segment
        step(1'b1, 0);
        step(1'b1, 65535);
        step(1'b1, 16384);
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b1, 65300);
        // full scrambled sweep with idle gaps
        for (int i = 0; i < 65536; i++) begin
            if ((i % 7) == 3) step(1'b0, (i * 13) & 16'hFFFF);
            step(1'b1, (i * 40503) & 16'hFFFF);
        end
        // flush
        for (int i = 0; i < 4; i++) step(1'b0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule